// File: doc/BRIEF.md
# Split-Section Presettable Decade Counter

A four-bit counter made of two sections with separate count clocks. The low section is a single toggle bit on output bit 0, advanced by `cntClkA`. The high section is three bits on output bits 3..1, advanced by `cntClkB`. It counts modulo five by default, or modulo eight when the `HI_MOD8` parameter is set. Both sections step on falling edges of their own count clock. The count clocks, the clear and the load are sampled into a single system clock domain through synchronizers, so the whole block is ordinary synchronous logic.

The order of the count depends on how the sections are wired together outside the block. Feeding the input to `cntClkA` and wiring output bit 0 to `cntClkB` gives a BCD count 0..9. Feeding the input to `cntClkB` and wiring output bit 3 to `cntClkA` gives the bi-quinary order, in which bit 0 is a divide-by-ten square wave. With `HI_MOD8` set, the first wiring gives a plain modulo-16 counter. An active-low clear forces the output to zero at once and wins over everything else. An active-low load makes the output track `loadVal` for as long as it is held, and the count clocks have no effect during that time.

Top module: `dual_section_counter`

## Requirements
- R1: While `clrN` is low, `cnt` is 0000 without waiting for `sysClk`. This holds even while `loadN` is low.
- R2: While `loadN` is low and `clrN` is high, `cnt` follows `loadVal`, including changes made during the load. Falling edges on either count clock have no effect during that time.
- R3: `cnt[0]` toggles on each falling edge of `cntClkA`. A rising edge of `cntClkA` changes nothing.
- R4: With `HI_MOD8`=0, `cnt[3:1]` steps 000,001,010,011,100 and then back to 000, on falling edges of `cntClkB`. `cnt[0]` is not affected.
- R5: With `HI_MOD8`=0, a high-section code of 101, 110 or 111 becomes 000 on the next falling edge of `cntClkB`. `cnt[0]` keeps its value.
- R6: With the input on `cntClkA` and `cnt[0]` wired to `cntClkB`, `cnt` counts 0,1,...,9 and wraps to 0.
- R7: With the input on `cntClkB` and `cnt[3]` wired to `cntClkA`, `cnt` follows 2,4,6,8,1,3,5,7,9,0. `cnt[0]` is high for exactly 5 of every 10 input edges.
- R8: With `HI_MOD8`=1 and `cnt[0]` wired to `cntClkB`, `cnt` counts 0..15 and wraps to 0.
- R9: After `loadN` returns high, counting resumes from the loaded value on the next falling count edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; every sampled input and all state use its rising edge |
| cntClkA | input | 1 | Count clock of the low section (bit 0), active on its falling edge |
| cntClkB | input | 1 | Count clock of the high section (bits 3..1), active on its falling edge |
| clrN | input | 1 | Active-low clear; highest priority |
| loadN | input | 1 | Active-low transparent load |
| loadVal | input | 4 | Value loaded while `loadN` is low |
| cnt | output | 4 | Counter value; bit 0 is the low section |

## Verification
The bench builds two instances. One uses the default `HI_MOD8`=0 and the other uses `HI_MOD8`=1, both with two synchronizer stages. The default instance covers the modulo-five section: the BCD and bi-quinary wirings, transparent load, clear priority and recovery from the three illegal high-section codes. The modulo-eight instance makes the straight 0..15 wrap reachable. The bench makes each wiring inside the bench, by routing one instance output back onto the other count clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic loadNow;   // capture loadVal this cycle
    logic stepLow;   // toggle the low section
    logic stepHigh;  // advance the high section
  } dscStep_t;

endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     sysClk,
  input  logic     clrN,
  input  logic     cntClkA,
  input  logic     cntClkB,
  input  logic     loadN,
  output logic     runN,
  output dscStep_t ctl
);

  localparam int NSIG = 3;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_LOAD = 2;
  // Idle levels after clear: count clocks low, load inactive (high)
  localparam logic [NSIG-1:0] IDLE_PAT = 3'b100;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] synced;
  logic [NSIG-1:0] prevS;
  logic [NSIG-1:0] fallS;
  logic            holdOff;
  logic [SYNC_STAGES-1:0] rstStg;

  assign rawIn = {loadN, cntClkB, cntClkA};

  // Clear: asserts at once, releases through the synchronizer chain
  always_ff @(posedge sysClk or negedge clrN) begin
    if (!clrN) rstStg <= '0;
    else       rstStg <= {rstStg[SYNC_STAGES-2:0], 1'b1};
  end
  assign runN = rstStg[SYNC_STAGES-1];

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge sysClk or negedge clrN) begin
      if (!clrN) stg <= {SYNC_STAGES{IDLE_PAT[g]}};
      else       stg <= {stg[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = stg[SYNC_STAGES-1];
  end

  always_ff @(posedge sysClk or negedge clrN) begin
    if (!clrN) prevS <= IDLE_PAT;
    else       prevS <= synced;
  end

  assign fallS = prevS & ~synced;
  // No stepping while loading, nor in the cycle the load releases
  assign holdOff = ~synced[IDX_LOAD] | ~prevS[IDX_LOAD];

  always_comb begin
    ctl.loadNow  = ~synced[IDX_LOAD];
    ctl.stepLow  = fallS[IDX_A] & ~holdOff;
    ctl.stepHigh = fallS[IDX_B] & ~holdOff;
  end

endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter bit HI_MOD8 = 1'b0
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  dscStep_t         ctl,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt
);

  localparam int HI_W = CNT_W - 1;
  localparam logic [HI_W-1:0] HI_LAST =
    HI_MOD8 ? HI_W'((1 << HI_W) - 1) : HI_W'(4);

  logic [HI_W-1:0] hiCur;
  logic [HI_W-1:0] hiNext;

  assign hiCur = cnt[CNT_W-1:1];
  // Codes above the last legal value fall back to zero as well
  assign hiNext = (hiCur >= HI_LAST) ? '0 : hiCur + HI_W'(1);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadNow) begin
      cnt <= loadVal;
    end else begin
      if (ctl.stepLow)  cnt[0]         <= ~cnt[0];
      if (ctl.stepHigh) cnt[CNT_W-1:1] <= hiNext;
    end
  end

endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter
  import dsc_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter bit HI_MOD8     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             cntClkA,
  input  logic             cntClkB,
  input  logic             clrN,
  input  logic             loadN,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt
);

  dscStep_t ctl;
  logic     runN;

  dsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk (sysClk),
    .clrN   (clrN),
    .cntClkA(cntClkA),
    .cntClkB(cntClkB),
    .loadN  (loadN),
    .runN   (runN),
    .ctl    (ctl)
  );

  dsc_datapath #(.CNT_W(CNT_W), .HI_MOD8(HI_MOD8)) u_dp (
    .sysClk (sysClk),
    .rstN   (runN),
    .ctl    (ctl),
    .loadVal(loadVal),
    .cnt    (cnt)
  );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter bit HI_MOD8 = 1'b0
) (
  input logic             sysClk,
  input logic             clrN,
  input logic             runN,
  input dscStep_t         ctl,
  input logic [CNT_W-1:0] loadVal,
  input logic [CNT_W-1:0] cnt
);

  // R1: clear forces zero regardless of load
  p_clear_zero_r1: assert property (@(posedge sysClk)
    !clrN |-> (cnt == '0));

  // R2: load captures the value presented
  p_load_follow_r2: assert property (@(posedge sysClk) disable iff (!runN)
    ctl.loadNow |=> (cnt == $past(loadVal)));

  // R3: a low step flips bit 0
  p_low_toggle_r3: assert property (@(posedge sysClk) disable iff (!runN)
    (ctl.stepLow && !ctl.loadNow) |=> (cnt[0] != $past(cnt[0])));

  // R9: with no strobe the count holds
  p_idle_hold_r9: assert property (@(posedge sysClk) disable iff (!runN)
    (!ctl.loadNow && !ctl.stepLow && !ctl.stepHigh) |=> $stable(cnt));

  if (!HI_MOD8) begin : g_mod5
    // R4 / R5: after any high step the code is legal
    p_high_legal_r5: assert property (@(posedge sysClk) disable iff (!runN)
      (ctl.stepHigh && !ctl.loadNow) |=> (cnt[CNT_W-1:1] <= 3'd4));
  end

endmodule

bind dual_section_counter dsc_checker #(.CNT_W(CNT_W), .HI_MOD8(HI_MOD8)) u_chk (
  .sysClk (sysClk),
  .clrN   (clrN),
  .runN   (runN),
  .ctl    (ctl),
  .loadVal(loadVal),
  .cnt    (cnt)
);

// File: tb/dual_section_counter_tb.sv
`timescale 1ns/1ps
module dual_section_counter_tb;

  logic sysClk = 1'b0;
  always #2.5 sysClk = ~sysClk;

  logic       clrN = 1'b0, loadN = 1'b1;
  logic       extA = 1'b0, extB = 1'b0, extAb = 1'b0;
  logic [3:0] pVal = 4'd0;
  int         wireMode = 0;  // 0 none, 1 low->high chain, 2 high->low chain
  logic [3:0] q, qb;
  logic       cpA, cpB, cpBb;

  assign cpA  = (wireMode == 2) ? q[3] : extA;
  assign cpB  = (wireMode == 1) ? q[0] : extB;
  assign cpBb = qb[0];

  dual_section_counter #(.HI_MOD8(1'b0)) u_dut (
    .sysClk(sysClk), .cntClkA(cpA), .cntClkB(cpB), .clrN(clrN),
    .loadN(loadN), .loadVal(pVal), .cnt(q));

  dual_section_counter #(.HI_MOD8(1'b1)) u_dutBin (
    .sysClk(sysClk), .cntClkA(extAb), .cntClkB(cpBb), .clrN(clrN),
    .loadN(1'b1), .loadVal(4'd0), .cnt(qb));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] expQ[$];
  string      tagQ[$];
  bit         selQ[$];

  task automatic cyc(int n);
    repeat (n) @(negedge sysClk);
  endtask

  // driver side of the scoreboard
  task automatic pushExp(bit sel, logic [3:0] v, string tag);
    expQ.push_back(v); tagQ.push_back(tag); selQ.push_back(sel);
    while (expQ.size() != 0) @(negedge sysClk);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge sysClk);
      if (expQ.size() != 0) begin
        logic [3:0] v;
        string      t;
        bit         s;
        logic [3:0] act;
        v = expQ.pop_front(); t = tagQ.pop_front(); s = selQ.pop_front();
        act = s ? qb : q;
        checks++;
        if (act !== v) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, act, v);
        end
      end
    end
  end

  task automatic edgeHigh(int which);
    case (which)
      0: extA = 1'b1; 1: extB = 1'b1; default: extAb = 1'b1;
    endcase
    cyc(6);
  endtask

  task automatic edgeLow(int which);
    case (which)
      0: extA = 1'b0; 1: extB = 1'b0; default: extAb = 1'b0;
    endcase
    cyc(14);
  endtask

  task automatic pulse(int which);
    edgeHigh(which);
    edgeLow(which);
  endtask

  task automatic restart(int mode);
    clrN = 1'b0; cyc(2);
    wireMode = mode;
    cyc(2);
    clrN = 1'b1; cyc(10);
  endtask

  function automatic logic [2:0] hiStep(logic [2:0] h, bit mod8);
    if (mod8) return h + 3'd1;
    return (h >= 3'd4) ? 3'd0 : h + 3'd1;
  endfunction

  initial begin
    logic [3:0] mdl;
    logic [2:0] hi, oldHi;
    logic       lo;
    int         highCnt;
    cyc(3);
    pushExp(0, 4'b0000, "R1 clear holds zero");
    pushExp(1, 4'b0000, "R1 clear holds zero (mod8)");
    clrN = 1'b1; cyc(10);

    // R3: rising edge does nothing, falling toggles
    edgeHigh(0); cyc(8);
    pushExp(0, 4'b0000, "R3 rising edge ignored");
    edgeLow(0);
    pushExp(0, 4'b0001, "R3 falling edge toggles");
    pulse(0);
    pushExp(0, 4'b0000, "R3 second toggle");

    // R4: high section alone, modulo five
    hi = 3'd0;
    for (int i = 0; i < 6; i++) begin
      pulse(1);
      hi = hiStep(hi, 1'b0);
      pushExp(0, {hi, 1'b0}, "R4 high section step");
    end

    // R6: BCD chain
    restart(1);
    mdl = 4'd0;
    for (int i = 0; i < 11; i++) begin
      pulse(0);
      mdl = (mdl == 4'd9) ? 4'd0 : mdl + 4'd1;
      pushExp(0, mdl, "R6 BCD order");
    end

    // R7: bi-quinary chain
    restart(2);
    hi = 3'd0; lo = 1'b0; highCnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1);
      oldHi = hi;
      hi = hiStep(hi, 1'b0);
      if (oldHi[2] && !hi[2]) lo = ~lo;
      if (q[0]) highCnt++;
      pushExp(0, {hi, lo}, "R7 bi-quinary order");
    end
    checks++;
    if (highCnt != 5) begin
      errors++;
      $display("FAIL R7 duty: got %0d expected 5", highCnt);
    end

    // R8: modulo-16 instance
    restart(0);
    for (int i = 1; i <= 17; i++) begin
      pulse(2);
      pushExp(1, 4'(i % 16), "R8 modulo 16");
    end

    // R2: transparent load, count clocks ignored
    restart(0);
    pVal = 4'b0110; loadN = 1'b0; cyc(6);
    pushExp(0, 4'b0110, "R2 load value");
    pVal = 4'b1001; cyc(6);
    pushExp(0, 4'b1001, "R2 load tracks change");
    pulse(0); pulse(1);
    pushExp(0, 4'b1001, "R2 clocks ignored in load");

    // R1: clear beats load
    pVal = 4'b0101;
    clrN = 1'b0; cyc(1);
    pushExp(0, 4'b0000, "R1 clear over load");
    clrN = 1'b1; cyc(10);
    pushExp(0, 4'b0101, "R2 load after clear");

    // R9: resume from loaded value
    loadN = 1'b1; cyc(10);
    pushExp(0, 4'b0101, "R9 value kept on release");
    pulse(0);
    pushExp(0, 4'b0100, "R9 resume low section");
    pulse(1);
    pushExp(0, 4'b0110, "R9 resume high section");

    // R5: illegal high codes recover
    pVal = 4'b1011; loadN = 1'b0; cyc(6); loadN = 1'b1; cyc(10);
    pulse(1);
    pushExp(0, 4'b0001, "R5 code 101 recovers");
    pVal = 4'b1100; loadN = 1'b0; cyc(6); loadN = 1'b1; cyc(10);
    pulse(1);
    pushExp(0, 4'b0000, "R5 code 110 recovers");
    pVal = 4'b1110; loadN = 1'b0; cyc(6); loadN = 1'b1; cyc(10);
    pulse(1);
    pushExp(0, 4'b0000, "R5 code 111 recovers");
    pVal = 4'b1001; loadN = 1'b0; cyc(6); loadN = 1'b1; cyc(10);
    pulse(1);
    pushExp(0, 4'b0001, "R4 code 100 wraps");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule